// File: doc/BRIEF.md
# Add/Subtract Arithmetic Unit with Condition Flags

This block is the add/subtract slice of a small RISC execution stage. Each cycle it may take one operation: a destination operand, a source operand, a short immediate field, the current carry flag and an operation code. One cycle later it presents the arithmetic result, a write-back enable and fresh zero, negative and carry flags. It supports plain, carry-chained and immediate forms of addition and subtraction, two compare forms that only touch the flags, and negation.

Every subtracting operation runs through one shared adder. The second operand is inverted and the carry input is chosen so that the adder computes the difference. The carry flag then reports an unsigned borrow: it is set when the amount taken away is larger, as unsigned values, than the operand it is taken from. Quick immediates are formed next to the adder. A quick add or subtract reads an immediate field of zero as 32. The quick compare reads the field as a signed value.

The datapath width and the immediate width are parameters. At the defaults the unit is 32 bits wide with a 5-bit immediate field.

Top module: `arith_addsub_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first accepted operation, out_valid, wr_en, result, flag_z, flag_n and flag_c are all 0.
- R2: An operation is accepted when in_valid is high on a rising clock edge and op_sel is a legal code (0 to 8). out_valid is high in the cycle after each accepted operation and low in every other cycle. Codes 9 to 15 are never accepted.
- R3: The op_sel codes are 0 ADD, 1 ADDC, 2 ADDQ, 3 SUB, 4 SUBC, 5 SUBQ, 6 CMP, 7 CMPQ and 8 NEG. wr_en goes high together with out_valid for every accepted code except 6 (CMP) and 7 (CMPQ). For a compare, result still shows the difference.
- R4: After each accepted operation, flag_z is 1 exactly when result is zero, and flag_n equals the most significant bit of result.
- R5: ADD and ADDQ produce dst_val plus the second operand, modulo 2^WIDTH. flag_c is 1 exactly when the true sum does not fit in WIDTH bits, that is, on unsigned overflow.
- R6: ADDC produces dst_val + src_val + carry_in. flag_c is the carry out of this full three-input sum. For example, all-ones plus zero with carry_in 1 gives result 0 and flag_c 1.
- R7: SUB and CMP compute dst_val - src_val, and SUBC computes dst_val - src_val - carry_in. flag_c is 1 exactly when the subtracted amount (src_val, or src_val + carry_in for SUBC) is larger than dst_val as unsigned values.
- R8: ADDQ and SUBQ use imm_val zero-extended as the second operand, except that an imm_val of 0 stands for 32.
- R9: CMPQ subtracts imm_val read as a two's-complement value from -16 to +15, sign-extended to WIDTH. The carry flag is the unsigned borrow against that extended value.
- R10: NEG produces 0 - dst_val. flag_c is 1 exactly when dst_val is nonzero.
- R11: carry_in has no effect on the result or flags of ADD, ADDQ, SUB, SUBQ, CMP, CMPQ or NEG.
- R12: In a cycle with no accepted operation (in_valid low, or an illegal code), result and all three flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 4 | Operation code (see R3) |
| dst_val | input | WIDTH | Destination operand, the minuend of subtractions |
| src_val | input | WIDTH | Source operand |
| imm_val | input | IMM_W | Immediate field for quick forms |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result and flags updated this cycle |
| wr_en | output | 1 | Result should be written back |
| result | output | WIDTH | Arithmetic result |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry / borrow flag |

## Verification
The bench builds two copies side by side and feeds both the same stimulus: one at the default 32-bit width and one at WIDTH=8, both with a 5-bit immediate. The narrow copy makes carry-out, borrow and zero results common under random operands. It also puts the quick immediate of 32 and the sign-extended -16 at a significant fraction of the full range, so the wrap and sign-extension paths are exercised far more densely than the wide copy alone would allow. The wide copy covers the all-ones carry-chain corners at full width.

// File: rtl/arith_pkg.sv
package arith_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_ADDQ = 4'd2,
    OP_SUB  = 4'd3,
    OP_SUBC = 4'd4,
    OP_SUBQ = 4'd5,
    OP_CMP  = 4'd6,
    OP_CMPQ = 4'd7,
    OP_NEG  = 4'd8
  } op_e;

  function automatic logic op_legal(logic [3:0] code);
    return code <= 4'd8;
  endfunction

  function automatic logic op_is_compare(logic [3:0] code);
    return (code == OP_CMP) || (code == OP_CMPQ);
  endfunction

endpackage

// File: rtl/arith_imm_conv.sv
// Forms the two immediate interpretations used by the quick operations.
module arith_imm_conv #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 5
) (
  input  logic [IMM_W-1:0] imm_i,
  output logic [WIDTH-1:0] quick_o,
  output logic [WIDTH-1:0] signed_o
);
  localparam int PAD_Q = WIDTH - IMM_W - 1;
  localparam int PAD_S = WIDTH - IMM_W;

  logic [IMM_W:0] quick_ext;

  // A zero field stands for 2**IMM_W.
  always_comb begin
    if (imm_i == '0) quick_ext = {1'b1, {IMM_W{1'b0}}};
    else             quick_ext = {1'b0, imm_i};
  end

  assign quick_o  = {{PAD_Q{1'b0}}, quick_ext};
  assign signed_o = {{PAD_S{imm_i[IMM_W-1]}}, imm_i};
endmodule

// File: rtl/arith_adder.sv
// Single carry chain shared by every operation.
module arith_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH:0] full_sum;

  assign full_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
  assign sum_o    = full_sum[WIDTH-1:0];
  assign cout_o   = full_sum[WIDTH];
endmodule

// File: rtl/arith_flags.sv
// Derives condition flags from the adder output.
module arith_flags #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] sum_i,
  input  logic             cout_i,
  input  logic             borrow_mode_i,
  output logic             z_o,
  output logic             n_o,
  output logic             c_o
);
  assign z_o = (sum_i == '0);
  assign n_o = sum_i[WIDTH-1];
  // With an inverted subtrahend, a missing carry out means a borrow.
  assign c_o = borrow_mode_i ? ~cout_i : cout_i;
endmodule

// File: rtl/arith_addsub_unit.sv
module arith_addsub_unit
  import arith_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [3:0]       op_sel,
  input  logic [WIDTH-1:0] dst_val,
  input  logic [WIDTH-1:0] src_val,
  input  logic [IMM_W-1:0] imm_val,
  input  logic             carry_in,
  output logic             out_valid,
  output logic             wr_en,
  output logic [WIDTH-1:0] result,
  output logic             flag_z,
  output logic             flag_n,
  output logic             flag_c
);

  logic [WIDTH-1:0] quick_imm;
  logic [WIDTH-1:0] signed_imm;
  logic [WIDTH-1:0] opa;
  logic [WIDTH-1:0] opb_raw;
  logic [WIDTH-1:0] opb;
  logic             opc;
  logic             subtracting;
  logic [WIDTH-1:0] sum;
  logic             cout;
  logic             z_nxt;
  logic             n_nxt;
  logic             c_nxt;
  logic             take;
  logic             wr_nxt;

  arith_imm_conv #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_imm (
    .imm_i    (imm_val),
    .quick_o  (quick_imm),
    .signed_o (signed_imm)
  );

  // Operand steering: subtraction is a + ~b + 1, less the carry for SUBC.
  always_comb begin
    opa         = dst_val;
    opb_raw     = src_val;
    opc         = 1'b0;
    subtracting = 1'b0;
    case (op_sel)
      OP_ADD:  ;
      OP_ADDC: opc = carry_in;
      OP_ADDQ: opb_raw = quick_imm;
      OP_SUB, OP_CMP: begin
        subtracting = 1'b1;
        opc         = 1'b1;
      end
      OP_SUBC: begin
        subtracting = 1'b1;
        opc         = ~carry_in;
      end
      OP_SUBQ: begin
        opb_raw     = quick_imm;
        subtracting = 1'b1;
        opc         = 1'b1;
      end
      OP_CMPQ: begin
        opb_raw     = signed_imm;
        subtracting = 1'b1;
        opc         = 1'b1;
      end
      OP_NEG: begin
        opa         = '0;
        opb_raw     = dst_val;
        subtracting = 1'b1;
        opc         = 1'b1;
      end
      default: ;
    endcase
    opb = subtracting ? ~opb_raw : opb_raw;
  end

  arith_adder #(.WIDTH(WIDTH)) u_add (
    .a_i    (opa),
    .b_i    (opb),
    .cin_i  (opc),
    .sum_o  (sum),
    .cout_o (cout)
  );

  arith_flags #(.WIDTH(WIDTH)) u_flg (
    .sum_i         (sum),
    .cout_i        (cout),
    .borrow_mode_i (subtracting),
    .z_o           (z_nxt),
    .n_o           (n_nxt),
    .c_o           (c_nxt)
  );

  assign take   = in_valid & op_legal(op_sel);
  assign wr_nxt = take & ~op_is_compare(op_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
    end else begin
      out_valid <= take;
      wr_en     <= wr_nxt;
    end
  end

  // Result and flag registers load only on an accepted operation.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      flag_z <= 1'b0;
      flag_n <= 1'b0;
      flag_c <= 1'b0;
    end else if (take) begin
      result <= sum;
      flag_z <= z_nxt;
      flag_n <= n_nxt;
      flag_c <= c_nxt;
    end
  end

endmodule

// File: rtl/arith_addsub_chk.sv
module arith_addsub_chk
  import arith_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [3:0]       op_sel,
  input logic [WIDTH-1:0] dst_val,
  input logic             out_valid,
  input logic             wr_en,
  input logic [WIDTH-1:0] result,
  input logic             flag_z,
  input logic             flag_n,
  input logic             flag_c
);

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_legal(op_sel)) |=> out_valid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && op_legal(op_sel)) |=> !out_valid);

  assert_cmp_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_is_compare(op_sel)) |=> !wr_en);

  assert_wr_with_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> out_valid);

  assert_zero_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flag_z == (result == '0)));

  assert_neg_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flag_n == result[WIDTH-1]));

  assert_add_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_ADD) |=> (flag_c == (result < $past(dst_val))));

  assert_neg_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_NEG) |=> (flag_c == (result != '0)));

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && op_legal(op_sel)) |=>
      ($stable(result) && $stable(flag_z) && $stable(flag_n) && $stable(flag_c)));

endmodule

bind arith_addsub_unit arith_addsub_chk #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_sel    (op_sel),
  .dst_val   (dst_val),
  .out_valid (out_valid),
  .wr_en     (wr_en),
  .result    (result),
  .flag_z    (flag_z),
  .flag_n    (flag_n),
  .flag_c    (flag_c)
);

// File: tb/arith_addsub_unit_test.sv
`timescale 1ns/1ps
module arith_addsub_unit_test;

  localparam int IMM_W = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [3:0] op_sel;
  logic [31:0] dst_w, src_w;
  logic [7:0]  dst_n, src_n;
  logic [IMM_W-1:0] imm_val;
  logic carry_in;

  logic ov_w, we_w, z_w, n_w, c_w;
  logic [31:0] res_w;
  logic ov_n, we_n, z_n, n_n, c_n;
  logic [7:0] res_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Expected registered state, index 0 = 32-bit copy, 1 = 8-bit copy.
  int     wid [2] = '{32, 8};
  longint e_res [2];
  bit     e_z [2], e_n [2], e_c [2], e_ov [2], e_we [2];

  always #2 clk = ~clk;

  arith_addsub_unit #(.WIDTH(32), .IMM_W(IMM_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .dst_val(dst_w), .src_val(src_w), .imm_val(imm_val), .carry_in(carry_in),
    .out_valid(ov_w), .wr_en(we_w), .result(res_w),
    .flag_z(z_w), .flag_n(n_w), .flag_c(c_w)
  );

  arith_addsub_unit #(.WIDTH(8), .IMM_W(IMM_W)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .dst_val(dst_n), .src_val(src_n), .imm_val(imm_val), .carry_in(carry_in),
    .out_valid(ov_n), .wr_en(we_n), .result(res_n),
    .flag_z(z_n), .flag_n(n_n), .flag_c(c_n)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string op_tag(int op);
    case (op)
      0, 2:    return "R5";
      1:       return "R6";
      3, 4, 6: return "R7";
      5:       return "R8";
      7:       return "R9";
      8:       return "R10";
      default: return "R12";
    endcase
  endfunction

  // Behavioural reference: updates the expected registers of copy i.
  task automatic model(int i, int op, longint a, longint b, int imm, int cin, bit vld);
    longint mask, q, sv, res, full;
    bit c;
    int w;
    w    = wid[i];
    mask = (64'sd1 <<< w) - 1;
    a    = a & mask;
    b    = b & mask;
    q    = (imm == 0) ? 32 : imm;
    sv   = ((imm >= 16) ? longint'(imm - 32) : longint'(imm)) & mask;
    res  = 0;
    c    = 0;
    case (op)
      0: begin full = a + b;             res = full & mask; c = full > mask; end
      1: begin full = a + b + cin;       res = full & mask; c = full > mask; end
      2: begin full = a + q;             res = full & mask; c = full > mask; end
      3, 6: begin res = (a - b) & mask;       c = b > a; end
      4: begin res = (a - b - cin) & mask;    c = (b + cin) > a; end
      5: begin res = (a - q) & mask;          c = q > a; end
      7: begin res = (a - sv) & mask;         c = sv > a; end
      8: begin res = (0 - a) & mask;          c = a != 0; end
      default: ;
    endcase
    if (vld && op <= 8) begin
      e_res[i] = res;
      e_z[i]   = (res == 0);
      e_n[i]   = res[w-1];
      e_c[i]   = c;
      e_ov[i]  = 1'b1;
      e_we[i]  = (op != 6) && (op != 7);
    end else begin
      e_ov[i] = 1'b0;
      e_we[i] = 1'b0;
    end
  endtask

  task automatic compare_all(string tag);
    for (int i = 0; i < 2; i++) begin
      longint ares;
      bit aov, awe, az, an, ac;
      ares = (i == 0) ? longint'(res_w) : longint'(res_n);
      aov  = (i == 0) ? ov_w : ov_n;
      awe  = (i == 0) ? we_w : we_n;
      az   = (i == 0) ? z_w  : z_n;
      an   = (i == 0) ? n_w  : n_n;
      ac   = (i == 0) ? c_w  : c_n;
      check(aov == e_ov[i], "R2", $sformatf("w%0d out_valid", wid[i]), aov, e_ov[i]);
      check(awe == e_we[i], "R3", $sformatf("w%0d wr_en", wid[i]), awe, e_we[i]);
      check(ares == e_res[i], tag, $sformatf("w%0d result", wid[i]), ares, e_res[i]);
      check(az == e_z[i] && an == e_n[i], "R4", $sformatf("w%0d z/n", wid[i]),
            {az, an}, {e_z[i], e_n[i]});
      check(ac == e_c[i], tag, $sformatf("w%0d flag_c", wid[i]), ac, e_c[i]);
    end
  endtask

  // Drive at a falling edge, let the rising edge capture, compare at the next falling edge.
  task automatic step(int op, longint a, longint b, int imm, int cin, bit vld, string tag);
    in_valid = vld;
    op_sel   = 4'(op);
    dst_w    = a[31:0];
    src_w    = b[31:0];
    dst_n    = a[7:0];
    src_n    = b[7:0];
    imm_val  = IMM_W'(imm);
    carry_in = cin[0];
    for (int i = 0; i < 2; i++) model(i, op, a, b, imm, cin, vld);
    @(negedge clk);
    compare_all((tag == "") ? op_tag(op) : tag);
  endtask

  function automatic longint pick_operand();
    case ($urandom_range(0, 5))
      0: return 0;
      1: return 64'hFFFF_FFFF;
      2: return 64'h8000_0080;
      3: return 1;
      default: return longint'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 0; op_sel = 0; dst_w = 0; src_w = 0;
    dst_n = 0; src_n = 0; imm_val = 0; carry_in = 0;
    for (int i = 0; i < 2; i++) begin
      e_res[i] = 0; e_z[i] = 0; e_n[i] = 0; e_c[i] = 0; e_ov[i] = 0; e_we[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state of both copies
    compare_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");

    // R5 / R6 carry corners
    step(0, 64'hFFFF_FFFF, 1, 0, 0, 1, "R5");
    step(0, 64'h7FFF_FFFF, 1, 0, 0, 1, "R5");
    step(1, 64'hFFFF_FFFF, 0, 0, 1, 1, "R6");
    step(1, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 0, 1, 1, "R6");
    step(1, 5, 6, 0, 1, 1, "R6");
    // R7 borrow corners
    step(3, 0, 1, 0, 0, 1, "R7");
    step(3, 5, 5, 0, 0, 1, "R7");
    step(4, 0, 0, 0, 1, 1, "R7");
    step(4, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 0, 1, 1, "R7");
    step(6, 3, 9, 0, 0, 1, "R3");
    // R8 quick immediate zero means 32
    step(2, 10, 0, 0, 0, 1, "R8");
    step(5, 32, 0, 0, 0, 1, "R8");
    step(5, 31, 0, 0, 0, 1, "R8");
    // R9 signed compare immediate
    step(7, 0, 0, 16, 0, 1, "R9");
    step(7, 64'hFFFF_FFF0, 0, 16, 0, 1, "R9");
    step(7, 20, 0, 15, 0, 1, "R9");
    // R10 negate
    step(8, 0, 0, 0, 0, 1, "R10");
    step(8, 1, 0, 0, 0, 1, "R10");
    // R11 carry_in ignored: same operands, carry_in set
    step(0, 64'hFFFF_FFFF, 1, 0, 1, 1, "R11");
    step(2, 7, 0, 3, 1, 1, "R11");
    step(3, 5, 5, 0, 1, 1, "R11");
    step(5, 40, 0, 0, 1, 1, "R11");
    step(6, 9, 3, 0, 1, 1, "R11");
    step(7, 1, 0, 17, 1, 1, "R11");
    step(8, 1, 0, 0, 1, 1, "R11");
    // R12 hold: idle strobe and illegal codes
    step(0, 123, 456, 0, 0, 0, "R12");
    step(9, 1, 2, 3, 1, 1, "R12");
    step(15, 0, 0, 0, 0, 1, "R12");
    step(3, 1, 1, 0, 0, 0, "R12");

    // Random mix, including back-to-back operations and idle cycles
    for (int k = 0; k < 3000; k++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op == 9) op = $urandom_range(9, 15);
      step(op, pick_operand(), pick_operand(), $urandom_range(0, 31),
           $urandom_range(0, 1), ($urandom_range(0, 7) != 0), "");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule